// File: doc/BRIEF.md
# Frame-Synchronised Double-Buffered Control Register Bank

This block sits between the write port of a serial bus slave and the control registers that a video datapath reads. Each register has two copies: an active value that drives the datapath and a pending shadow value. One bit of one control register sets the mode. With that bit clear, a write goes straight to the active register. With it set, a write is parked in the shadow copy. It reaches the active register on the next rising edge of the vertical-blank input, so a picture never changes in the middle of a frame.

A write-mask bit per register records which shadow entries hold new data. On the vertical-blank edge only those entries are copied, all in one clock, and the mask is cleared. While anything is pending the block reports busy. Any further write is dropped and flagged in the same cycle, so the bus slave can refuse the byte. The one exception is the register that holds the mode bit: writes to it always go straight through, so the mode can never lock itself out. A rising edge on the power-on-reset flag zeroes every register.

Top module: `vb_shadow_bank`

## Requirements
- R1: After rstN is released, every active register reads 0, busy is 0 and wrRefused is 0.
- R2: While bit 5 of register 0x0C is 0 (immediate mode), a write to any register appears on activeRegs in the cycle after the strobe. Register i occupies bits [8*i+7 : 8*i] of activeRegs.
- R3: While bit 5 of register 0x0C is 1 (buffered mode), a write to any register other than 0x0C leaves activeRegs unchanged until the next rising edge of vBlank.
- R4: On a rising edge of vBlank, every written shadow entry is copied to its active register in that single clock. Registers not written keep their active value.
- R5: busy goes high in the cycle after a buffered write and falls in the cycle after the vBlank rising edge that commits it.
- R6: While busy is 1, a write to any register other than 0x0C raises wrRefused in the same cycle and is dropped. The pending value and the active value both stay as they were.
- R7: A write to register 0x0C takes effect in the cycle after the strobe in either mode, even while busy, and never raises wrRefused.
- R8: Only a 0-to-1 change of vBlank commits. A buffered write made while vBlank stays high waits for the next rising edge.
- R9: A buffered write in the same cycle as a vBlank rising edge, with nothing pending, is not copied by that edge. It stays pending and busy goes high.
- R10: A 0-to-1 change of porFlag clears every active register, shadow entry and pending mark to 0 in the next cycle. Holding porFlag high does not clear again, so writes made afterwards take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porFlag | input | 1 | Power-on-reset flag; its rising edge clears the bank |
| wrEn | input | 1 | Write strobe from the bus slave |
| wrAddr | input | 4 | Register index for the write |
| wrData | input | 8 | Write data |
| vBlank | input | 1 | Vertical-blank pulse; its rising edge commits pending data |
| activeRegs | output | 128 | Flattened active register values, register i at bits [8*i+7:8*i] |
| busy | output | 1 | High while buffered data waits for vertical blank |
| wrRefused | output | 1 | High in a cycle whose write is dropped because the bank is busy |

## Verification
Two events can land in the same cycle: a buffered write and the vertical-blank edge that commits. The bench raises wrEn and vBlank on the same falling edge with nothing pending. It then expects the target register to keep its old value and busy to rise, and expects the data to arrive only on a later separate vBlank pulse. A second overlap is a write to the mode register while a commit is pending. The bench expects that write to take effect at once with no refusal, while the pending entry still commits on the next edge.

// File: rtl/vb_shadow_pkg.sv
package vb_shadow_pkg;
  // strobes from the control module to the datapath
  typedef struct packed {
    logic wrActive;  // write straight into the active register
    logic wrShadow;  // park the write in the shadow entry
    logic commit;    // vertical-blank rising edge: copy marked entries
    logic clearAll;  // power-on-reset rising edge: zero everything
  } bankStrobe_t;
endpackage

// File: rtl/vb_shadow_ctrl.sv
module vb_shadow_ctrl
  import vb_shadow_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int MODE_REG = 12,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porFlag,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              vBlank,
  input  logic              busy,
  input  logic              bufEn,
  output bankStrobe_t       strobe,
  output logic              wrRefused
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_REG);

  logic vBlankQ, porQ;
  logic isModeReg, accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vBlankQ <= 1'b0;
      porQ    <= 1'b0;
    end else begin
      vBlankQ <= vBlank;
      porQ    <= porFlag;
    end
  end

  assign isModeReg = (wrAddr == MODE_ADDR);
  // the mode register bypasses the lock so the mode can always be changed
  assign accept    = wrEn && (!busy || isModeReg);

  always_comb begin
    strobe.commit   = vBlank && !vBlankQ;
    strobe.clearAll = porFlag && !porQ;
    strobe.wrActive = accept && (isModeReg || !bufEn);
    strobe.wrShadow = accept && !isModeReg && bufEn;
  end

  assign wrRefused = wrEn && busy && !isModeReg;

  // R6: a refused write never reaches either register copy
  p_refused_dropped_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrRefused |-> !(strobe.wrActive || strobe.wrShadow));

  // R8: a vBlank level held high yields no second commit
  p_single_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.commit);
endmodule

// File: rtl/vb_shadow_data.sv
module vb_shadow_data
  import vb_shadow_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int MODE_REG = 12,
  parameter int MODE_BIT = 5,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrobe_t                strobe,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [NUM_REGS*DATA_W-1:0] activeFlat,
  output logic                       busy,
  output logic                       bufEn
);
  logic [DATA_W-1:0]   activeQ [NUM_REGS];
  logic [DATA_W-1:0]   shadowQ [NUM_REGS];
  logic [NUM_REGS-1:0] dirtyQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = (wrAddr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activeQ[i] <= '0;
        shadowQ[i] <= '0;
        dirtyQ[i]  <= 1'b0;
      end else if (strobe.clearAll) begin
        activeQ[i] <= '0;
        shadowQ[i] <= '0;
        dirtyQ[i]  <= 1'b0;
      end else begin
        if (strobe.commit && dirtyQ[i]) activeQ[i] <= shadowQ[i];
        if (strobe.wrActive && hit)     activeQ[i] <= wrData;
        if (strobe.commit)              dirtyQ[i]  <= 1'b0;
        if (strobe.wrShadow && hit) begin
          shadowQ[i] <= wrData;
          dirtyQ[i]  <= 1'b1;
        end
      end
    end

    assign activeFlat[i*DATA_W +: DATA_W] = activeQ[i];
  end

  assign busy  = |dirtyQ;
  assign bufEn = activeQ[MODE_REG][MODE_BIT];

  // R5: a shadow write leaves the bank busy
  p_busy_after_park_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrShadow && !strobe.clearAll |=> busy);

  // R4: a commit with no new parking empties the pending mask
  p_commit_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit && !strobe.wrShadow && !strobe.clearAll |=> !busy);

  // R6: nothing is parked while a commit is pending
  p_no_park_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.wrShadow);

  // R10: the reset-flag edge zeroes the bank
  p_por_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (activeFlat == '0) && !busy);

  // R2: a direct write is visible on the next cycle
  p_direct_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrActive && !strobe.clearAll |=> activeQ[$past(wrAddr)] == $past(wrData));
endmodule

// File: rtl/vb_shadow_bank.sv
module vb_shadow_bank
  import vb_shadow_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int MODE_REG = 12,
  parameter int MODE_BIT = 5,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       porFlag,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       vBlank,
  output logic [NUM_REGS*DATA_W-1:0] activeRegs,
  output logic                       busy,
  output logic                       wrRefused
);
  bankStrobe_t strobe;
  logic        bufEn;

  vb_shadow_ctrl #(.NUM_REGS(NUM_REGS), .MODE_REG(MODE_REG), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .porFlag(porFlag), .wrEn(wrEn), .wrAddr(wrAddr),
    .vBlank(vBlank), .busy(busy), .bufEn(bufEn), .strobe(strobe), .wrRefused(wrRefused)
  );

  vb_shadow_data #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .MODE_REG(MODE_REG),
                   .MODE_BIT(MODE_BIT), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .activeFlat(activeRegs), .busy(busy), .bufEn(bufEn)
  );
endmodule

// File: tb/tb_vb_shadow_bank.sv
module tb_vb_shadow_bank;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         porFlag = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   wrAddr = '0;
  logic [7:0]   wrData = '0;
  logic         vBlank = 1'b0;
  logic [127:0] activeRegs;
  logic         busy, wrRefused;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  vb_shadow_bank dut (
    .clk(clk), .rstN(rstN), .porFlag(porFlag), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .vBlank(vBlank), .activeRegs(activeRegs), .busy(busy),
    .wrRefused(wrRefused)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] regAt(input int idx);
    return activeRegs[idx*8 +: 8];
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write strobe; returns with outputs of the following cycle settled
  task automatic writeReg(input logic [3:0] a, input logic [7:0] d, output logic refused);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    #1 refused = wrRefused;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseVb();
    @(negedge clk); vBlank = 1'b1;
    @(negedge clk); vBlank = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 regs", activeRegs, '0);
    check("R1 busy", busy, 0);
    check("R1 refused", wrRefused, 0);
  endtask

  task automatic t_immediate();
    logic r;
    writeReg(4'd2, 8'h15, r);
    check("R2 reg2", regAt(2), 8'h15);
    check("R2 busy", busy, 0);
    writeReg(4'd0, 8'h3F, r);
    check("R2 reg0", regAt(0), 8'h3F);
  endtask

  task automatic t_buffered();
    logic r;
    writeReg(4'd12, 8'h20, r);           // enter buffered mode
    check("R7 reg12", regAt(12), 8'h20);
    writeReg(4'd4, 8'hA5, r);
    check("R3 reg4 held", regAt(4), 8'h00);
    check("R5 busy high", busy, 1);
    writeReg(4'd6, 8'h11, r);
    check("R6 refused flag", r, 1);
    check("R6 reg6", regAt(6), 8'h00);
    writeReg(4'd4, 8'h77, r);
    check("R6 refused flag2", r, 1);
    pulseVb();
    check("R4 reg4 copied", regAt(4), 8'hA5);
    check("R4 reg2 kept", regAt(2), 8'h15);
    check("R6 reg6 after", regAt(6), 8'h00);
    check("R5 busy low", busy, 0);
  endtask

  task automatic t_mode_while_busy();
    logic r;
    writeReg(4'd5, 8'h0C, r);
    check("R5 busy", busy, 1);
    writeReg(4'd12, 8'h21, r);
    check("R7 not refused", r, 0);
    check("R7 reg12 now", regAt(12), 8'h21);
    check("R3 reg5 held", regAt(5), 8'h00);
    pulseVb();
    check("R4 reg5 copied", regAt(5), 8'h0C);
  endtask

  task automatic t_level();
    logic r;
    @(negedge clk); vBlank = 1'b1;
    @(negedge clk);
    writeReg(4'd7, 8'h33, r);
    @(negedge clk);
    check("R8 reg7 waits", regAt(7), 8'h00);
    vBlank = 1'b0;
    @(negedge clk);
    check("R8 busy", busy, 1);
    pulseVb();
    check("R8 reg7 copied", regAt(7), 8'h33);
  endtask

  task automatic t_collide();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd8; wrData = 8'h44; vBlank = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; vBlank = 1'b0;
    check("R9 reg8 not copied", regAt(8), 8'h00);
    check("R9 busy", busy, 1);
    pulseVb();
    check("R9 reg8 later", regAt(8), 8'h44);
  endtask

  task automatic t_por();
    logic r;
    writeReg(4'd9, 8'h5A, r);
    @(negedge clk); porFlag = 1'b1;
    @(negedge clk);
    check("R10 regs zero", activeRegs, '0);
    check("R10 busy", busy, 0);
    writeReg(4'd3, 8'h12, r);            // flag still high, mode now immediate
    check("R10 held flag", regAt(3), 8'h12);
    porFlag = 1'b0;
    writeReg(4'd12, 8'h20, r);
    pulseVb();
    check("R10 shadow gone", regAt(9), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_buffered();
    t_mode_while_busy();
    t_level();
    t_collide();
    t_por();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule